// File: doc/BRIEF.md
# Gated Control Register Bank with Bus Address Extension

This block is a small slice of the control and status register file of a bus-master network controller. It keeps the byte pair that places the initialization block in memory, a second register index that mirrors that pair, a set of pointer registers (descriptor bases and buffer start addresses), and three interrupt mask bits. Software reaches all of it through a simple indexed register port with one cycle of read latency.

The address byte pair may only be read or written while the controller is stopped or suspended. The upper byte of that pair also serves as the top byte of every bus-master address when software uses 24-bit pointers. A mode input selects between 24-bit and 32-bit software pointers. In 24-bit mode the top byte of every stored pointer register is replaced by the upper address byte, so that register reads return the full 32-bit address. In 32-bit mode stored pointers are used as written.

An address-formation port returns the 32-bit bus-master address for the initialization block or for any pointer register in the same cycle. The mask bits gate three status inputs into one summary interrupt output.

Top module: `ctl_csr_bank`

## Requirements
- R1: The mask register at index 3 is readable and writable at all times. A write stores wdata bits 12 (missed frame), 11 (memory error) and 10 (receive). A read returns those three bits in the same positions and zero in every other bit. reg_rdata shows the register selected by reg_idx one clock edge earlier.
- R2: intr is high in the same cycle exactly when at least one of st_miss, st_merr and st_rint is high while its mask bit is clear.
- R3: Hardware reset (rst_n low at a clock edge) and soft_rst high at a clock edge both clear all three mask bits. soft_rst takes priority over a mask write in the same cycle. ctl_stop has no effect on the mask bits.
- R4: The address register at index 2 holds address bits 23:16 in data bits 7:0 and address bits 31:24 in data bits 15:8. It is written only when ctl_stop or ctl_suspend is high. Writes at other times are ignored. A read returns the pair in bits 15:0 when ctl_stop or ctl_suspend is high, and returns zero otherwise. Bits 31:16 always read as zero.
- R5: Neither hardware reset, soft_rst nor ctl_stop changes the stored address byte pair.
- R6: The mirror register at index 17 takes the same 16 bits as any accepted write to index 2. It can also be written directly under the same stop/suspend condition. A direct write to index 17 does not change index 2. Reads of index 17 follow the same rule as reads of index 2.
- R7: NUM_PTR pointer registers sit at indices 24 upward and can be written at any time. Hardware reset clears them and soft_rst does not. With mode32 high, a write stores all 32 bits unchanged, and the pointer registers are not touched otherwise.
- R8: With mode32 low, a pointer write stores the current upper address byte in bits 31:24 and the write data in bits 23:0. At every clock edge while mode32 is low, each pointer register's bits 31:24 are refreshed from the upper address byte, so reads return the combined 32-bit value.
- R9: With af_sel equal to 0, af_addr is {upper byte, bits 23:16 byte, 16'h0000}. With af_sel equal to k (1..NUM_PTR), af_addr is pointer k-1: unchanged in 32-bit mode, and with the current upper address byte in bits 31:24 in 24-bit mode. Any other af_sel gives zero. af_addr follows in the same cycle.
- R10: A read of any index not listed above returns zero, and reg_rdata is zero after hardware reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset |
| ctl_stop | input | 1 | Controller stopped |
| ctl_suspend | input | 1 | Controller suspended |
| mode32 | input | 1 | 1: 32-bit software pointers, 0: 24-bit |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 7 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| st_miss | input | 1 | Missed-frame status |
| st_merr | input | 1 | Memory-error status |
| st_rint | input | 1 | Receive status |
| intr | output | 1 | Summary interrupt |
| af_sel | input | SEL_W | Address-formation select |
| af_addr | output | 32 | Formed 32-bit bus-master address |

## Verification
The hardest state to reach is a pointer register that was written in 32-bit mode and then refreshed in 24-bit mode after the upper address byte changed. Reaching it needs, in order, a gated address write, a mode change and a pointer read, all while the stop and suspend inputs decide whether the address write is taken. The stimulus fixes this order once in a directed sequence. Random traffic then changes the mode, the stop and suspend inputs and soft_rst on their own schedules, so many such orders occur, each checked against a cycle model of the register state kept in the bench.

// File: rtl/csr_bank_pkg.sv
// Shared constants and types for the gated control register bank.
// Assumes 32-bit register data and a 7-bit register index.
package csr_bank_pkg;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = 7;
    localparam int MASK_LSB = 10;   // receive mask; memory error at +1, missed frame at +2
    localparam int MASK_W   = 3;

    typedef struct packed {
        logic miss;
        logic merr;
        logic rint;
    } irq_mask_t;
endpackage

// File: rtl/csr_iadr_reg.sv
// Holds the initialization address byte pair and its mirror register.
// Assumes the write strobes arrive already decoded and gated by the
// stop/suspend condition. The registers carry no reset on purpose: no
// reset of any kind changes them.
module csr_iadr_reg (
    input  logic        clk,
    input  logic        prim_we,
    input  logic        alias_we,
    input  logic [15:0] wdata,
    output logic [7:0]  addr_hi,
    output logic [7:0]  addr_mid,
    output logic [15:0] alias_q
);
    // Capture the byte pair on an accepted primary write.
    always_ff @(posedge clk) begin
        if (prim_we) begin
            {addr_hi, addr_mid} <= wdata;
        end
    end

    // Mirror follows every primary write and can also be written directly.
    always_ff @(posedge clk) begin
        if (prim_we || alias_we) begin
            alias_q <= wdata;
        end
    end
endmodule

// File: rtl/csr_irq_mask.sv
// Three interrupt mask bits and the summary interrupt.
// Assumes hardware and software resets are both synchronous; either one
// clears the masks and wins over a write in the same cycle.
module csr_irq_mask
    import csr_bank_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_rst,
    input  logic                  wr_en,
    input  logic [MASK_W-1:0]     wr_bits,
    input  logic                  st_miss,
    input  logic                  st_merr,
    input  logic                  st_rint,
    output irq_mask_t             mask_q,
    output logic                  intr
);
    // Mask storage with reset priority over writes.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= irq_mask_t'(wr_bits);
        end
    end

    // Summary interrupt from unmasked status inputs.
    always_comb begin
        intr = (st_miss & ~mask_q.miss) |
               (st_merr & ~mask_q.merr) |
               (st_rint & ~mask_q.rint);
    end
endmodule

// File: rtl/csr_ptr_bank.sv
// Pointer registers (descriptor bases, buffer starts) and the address
// former. In 24-bit mode the top byte of every pointer is replaced by the
// upper address byte, both on write and on every clock edge.
// Assumes wr_sel is one-hot or zero.
module csr_ptr_bank #(
    parameter int NUM_PTR = 4,
    parameter int SEL_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PTR-1:0]       wr_sel,
    input  logic [31:0]              wdata,
    input  logic                     mode32,
    input  logic [7:0]               addr_hi,
    input  logic [7:0]               addr_mid,
    input  logic [SEL_W-1:0]         af_sel,
    output logic [NUM_PTR-1:0][31:0] ptr_q,
    output logic [31:0]              af_addr
);
    for (genvar g = 0; g < NUM_PTR; g++) begin : g_slot
        logic [31:0] slot_q;

        // One pointer slot: write, or refresh of the top byte in 24-bit mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_sel[g]) begin
                slot_q <= mode32 ? wdata : {addr_hi, wdata[23:0]};
            end else if (!mode32) begin
                slot_q[31:24] <= addr_hi;
            end
        end

        assign ptr_q[g] = slot_q;
    end

    // Form the bus-master address for the selected source in the same cycle.
    always_comb begin
        af_addr = '0;
        if (af_sel == '0) begin
            af_addr = {addr_hi, addr_mid, 16'h0000};
        end
        for (int i = 0; i < NUM_PTR; i++) begin
            if (af_sel == SEL_W'(i + 1)) begin
                af_addr = mode32 ? ptr_q[i] : {addr_hi, ptr_q[i][23:0]};
            end
        end
    end
endmodule

// File: rtl/ctl_csr_bank.sv
// Top of the gated control register bank. Decodes the register port,
// gates address-register access on stop/suspend and registers read data
// (one cycle latency). Assumes one register access per cycle.
module ctl_csr_bank
    import csr_bank_pkg::*;
#(
    parameter int NUM_PTR      = 4,
    parameter int IADR_IDX     = 2,
    parameter int MASK_IDX     = 3,
    parameter int ALIAS_IDX    = 17,
    parameter int PTR_BASE_IDX = 24,
    localparam int SEL_W       = $clog2(NUM_PTR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              ctl_stop,
    input  logic              ctl_suspend,
    input  logic              mode32,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              st_miss,
    input  logic              st_merr,
    input  logic              st_rint,
    output logic              intr,
    input  logic [SEL_W-1:0]  af_sel,
    output logic [31:0]       af_addr
);
    logic                      addr_open;
    logic                      hit_iadr;
    logic                      hit_alias;
    logic                      hit_mask;
    logic [NUM_PTR-1:0]        hit_ptr;
    logic [7:0]                addr_hi;
    logic [7:0]                addr_mid;
    logic [15:0]               alias_q;
    irq_mask_t                 irq_mask;
    logic [NUM_PTR-1:0][31:0]  ptr_q;
    logic [DATA_W-1:0]         rd_next;

    // Index decode and the stop/suspend gate.
    always_comb begin
        addr_open = ctl_stop | ctl_suspend;
        hit_iadr  = (reg_idx == IDX_W'(IADR_IDX));
        hit_alias = (reg_idx == IDX_W'(ALIAS_IDX));
        hit_mask  = (reg_idx == IDX_W'(MASK_IDX));
    end

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_hit
        assign hit_ptr[g] = (reg_idx == IDX_W'(PTR_BASE_IDX + g));
    end

    csr_iadr_reg u_iadr (
        .clk      (clk),
        .prim_we  (reg_we & hit_iadr & addr_open),
        .alias_we (reg_we & hit_alias & addr_open),
        .wdata    (reg_wdata[15:0]),
        .addr_hi  (addr_hi),
        .addr_mid (addr_mid),
        .alias_q  (alias_q)
    );

    csr_irq_mask u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (reg_we & hit_mask),
        .wr_bits  (reg_wdata[MASK_LSB +: MASK_W]),
        .st_miss  (st_miss),
        .st_merr  (st_merr),
        .st_rint  (st_rint),
        .mask_q   (irq_mask),
        .intr     (intr)
    );

    csr_ptr_bank #(
        .NUM_PTR (NUM_PTR),
        .SEL_W   (SEL_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   ({NUM_PTR{reg_we}} & hit_ptr),
        .wdata    (reg_wdata),
        .mode32   (mode32),
        .addr_hi  (addr_hi),
        .addr_mid (addr_mid),
        .af_sel   (af_sel),
        .ptr_q    (ptr_q),
        .af_addr  (af_addr)
    );

    // Read multiplexer; reserved and unmapped bits read as zero.
    always_comb begin
        rd_next = '0;
        if (hit_iadr && addr_open) begin
            rd_next[15:0] = {addr_hi, addr_mid};
        end
        if (hit_alias && addr_open) begin
            rd_next[15:0] = alias_q;
        end
        if (hit_mask) begin
            rd_next[MASK_LSB +: MASK_W] = irq_mask;
        end
        for (int i = 0; i < NUM_PTR; i++) begin
            if (hit_ptr[i]) begin
                rd_next = ptr_q[i];
            end
        end
    end

    // Registered read data, one cycle after the index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else begin
            reg_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/ctl_csr_bank_chk.sv
// Property checker for ctl_csr_bank, attached by bind below.
module ctl_csr_bank_chk
    import csr_bank_pkg::*;
#(
    parameter int NUM_PTR   = 4,
    parameter int IADR_IDX  = 2,
    parameter int ALIAS_IDX = 17,
    parameter int SEL_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              ctl_stop,
    input logic              ctl_suspend,
    input logic              mode32,
    input logic              reg_we,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              st_miss,
    input logic              st_merr,
    input logic              st_rint,
    input logic              intr,
    input logic [SEL_W-1:0]  af_sel,
    input logic [31:0]       af_addr,
    input logic [7:0]        addr_hi,
    input logic [7:0]        addr_mid,
    input logic [15:0]       alias_q,
    input irq_mask_t         irq_mask
);
    // R4
    closed_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == IDX_W'(IADR_IDX) && !(ctl_stop || ctl_suspend))
        |=> $stable({addr_hi, addr_mid}));

    // R4
    closed_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == IDX_W'(IADR_IDX) && !(ctl_stop || ctl_suspend))
        |=> (reg_rdata == '0));

    // R6
    alias_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == IDX_W'(IADR_IDX) && (ctl_stop || ctl_suspend))
        |=> (alias_q == $past(reg_wdata[15:0])));

    // R2
    unmasked_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_miss && !irq_mask.miss) || (st_merr && !irq_mask.merr) ||
         (st_rint && !irq_mask.rint)) |-> intr);

    // R2
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!st_miss || irq_mask.miss) && (!st_merr || irq_mask.merr) &&
         (!st_rint || irq_mask.rint)) |-> !intr);

    // R3
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (irq_mask == '0));

    // R8
    upper_splice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode32 && af_sel != '0 && af_sel <= SEL_W'(NUM_PTR))
        |-> (af_addr[31:24] == addr_hi));

    // R9
    init_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (af_sel == '0) |-> (af_addr == {addr_hi, addr_mid, 16'h0000}));
endmodule

bind ctl_csr_bank ctl_csr_bank_chk #(
    .NUM_PTR   (NUM_PTR),
    .IADR_IDX  (IADR_IDX),
    .ALIAS_IDX (ALIAS_IDX),
    .SEL_W     (SEL_W)
) u_chk (.*);

// File: tb/ctl_csr_bank_test.sv
module ctl_csr_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int SW = 3;

    logic        clk = 1'b0;
    logic        rst_n, soft_rst, ctl_stop, ctl_suspend, mode32, reg_we;
    logic [6:0]  reg_idx;
    logic [31:0] reg_wdata, reg_rdata, af_addr;
    logic        st_miss, st_merr, st_rint, intr;
    logic [SW-1:0] af_sel;

    int checks = 0;
    int failures = 0;

    // bench model of architectural state
    logic [7:0]  m_hi, m_mid;
    logic [15:0] m_alias;
    logic [2:0]  m_mask;   // {miss, merr, rint}
    logic [31:0] m_ptr [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_csr_bank uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ctl_stop(ctl_stop),
        .ctl_suspend(ctl_suspend), .mode32(mode32), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .st_miss(st_miss), .st_merr(st_merr), .st_rint(st_rint), .intr(intr),
        .af_sel(af_sel), .af_addr(af_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read();
        logic open_q = ctl_stop | ctl_suspend;
        if (reg_idx == 7'd2)  return open_q ? {16'h0, m_hi, m_mid} : 32'h0;
        if (reg_idx == 7'd17) return open_q ? {16'h0, m_alias} : 32'h0;
        if (reg_idx == 7'd3)  return {19'h0, m_mask, 10'h0};
        for (int i = 0; i < NP; i++)
            if (reg_idx == 7'(24 + i)) return m_ptr[i];
        return 32'h0;
    endfunction

    function automatic string read_tag();
        if (reg_idx == 7'd2)  return "R4";
        if (reg_idx == 7'd17) return "R6";
        if (reg_idx == 7'd3)  return "R1";
        if (reg_idx >= 7'd24 && reg_idx < 7'(24 + NP)) return mode32 ? "R7" : "R8";
        return "R10";
    endfunction

    function automatic logic exp_intr();
        return (st_miss & ~m_mask[2]) | (st_merr & ~m_mask[1]) | (st_rint & ~m_mask[0]);
    endfunction

    function automatic logic [31:0] exp_af();
        if (af_sel == '0) return {m_hi, m_mid, 16'h0};
        for (int i = 0; i < NP; i++)
            if (af_sel == SW'(i + 1)) return mode32 ? m_ptr[i] : {m_hi, m_ptr[i][23:0]};
        return 32'h0;
    endfunction

    // apply one clock edge to the model using the inputs currently driven
    task automatic model_edge();
        logic [7:0] hi_old = m_hi;
        logic open_q = ctl_stop | ctl_suspend;
        for (int i = 0; i < NP; i++) begin
            if (reg_we && reg_idx == 7'(24 + i))
                m_ptr[i] = mode32 ? reg_wdata : {hi_old, reg_wdata[23:0]};
            else if (!mode32)
                m_ptr[i][31:24] = hi_old;
        end
        if (reg_we && reg_idx == 7'd2 && open_q) begin
            {m_hi, m_mid} = reg_wdata[15:0];
            m_alias = reg_wdata[15:0];
        end
        if (reg_we && reg_idx == 7'd17 && open_q) m_alias = reg_wdata[15:0];
        if (soft_rst) m_mask = 3'b000;
        else if (reg_we && reg_idx == 7'd3) m_mask = reg_wdata[12:10];
    endtask

    task automatic comb_checks(input bit with_af);
        chk("R2 intr", {31'h0, intr}, {31'h0, exp_intr()});
        if (with_af) chk("R9 af_addr", af_addr, exp_af());
    endtask

    // inputs are stable here; one edge, then compare registered read data
    task automatic cycle();
        logic [31:0] e = exp_read();
        string t = read_tag();
        @(posedge clk);
        #1;
        model_edge();
        chk({t, " rdata"}, reg_rdata, e);
    endtask

    task automatic set_op(input logic we, input logic [6:0] idx, input logic [31:0] d);
        reg_we = we; reg_idx = idx; reg_wdata = d;
    endtask

    task automatic hw_reset();
        rst_n = 1'b0; reg_we = 1'b0; soft_rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_mask = 3'b000;
        for (int i = 0; i < NP; i++) m_ptr[i] = 32'h0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        soft_rst = 0; ctl_stop = 0; ctl_suspend = 0; mode32 = 1;
        st_miss = 0; st_merr = 0; st_rint = 0; af_sel = '0;
        set_op(0, 7'd0, 32'h0);
        m_hi = 0; m_mid = 0; m_alias = 0;
        hw_reset();

        // reset state: R10 rdata zero, R3 masks clear, R7 pointers clear
        chk("R10 reset rdata", reg_rdata, 32'h0);
        st_miss = 1; st_merr = 1; st_rint = 1; #1;
        chk("R3 reset intr", {31'h0, intr}, 32'h1);
        set_op(0, 7'd3, 0); cycle();
        set_op(0, 7'd24, 0); cycle();

        // R4 gated write
        ctl_stop = 1; set_op(1, 7'd2, 32'hFFFF_A55A); cycle();
        set_op(0, 7'd2, 0); cycle();
        chk("R4 open read", reg_rdata, 32'h0000_A55A);
        ctl_stop = 0; set_op(1, 7'd2, 32'h0000_1234); cycle();
        set_op(0, 7'd2, 0); cycle();
        chk("R4 closed read", reg_rdata, 32'h0);
        ctl_suspend = 1; cycle();
        chk("R4 closed write ignored", reg_rdata, 32'h0000_A55A);
        // R6 mirror
        set_op(0, 7'd17, 0); cycle();
        set_op(1, 7'd17, 32'h7777); cycle();
        set_op(0, 7'd2, 0); cycle();
        chk("R6 direct mirror write leaves primary", reg_rdata, 32'h0000_A55A);
        set_op(0, 7'd17, 0); cycle();
        ctl_suspend = 0;

        // R1 mask
        set_op(1, 7'd3, 32'hFFFF_FFFF); cycle();
        set_op(0, 7'd3, 0); cycle();
        chk("R1 mask read", reg_rdata, 32'h0000_1C00);
        comb_checks(0);
        ctl_stop = 1; cycle(); cycle();
        chk("R3 stop keeps mask", reg_rdata, 32'h0000_1C00);
        soft_rst = 1; set_op(1, 7'd3, 32'h1C00); cycle();
        soft_rst = 0; set_op(0, 7'd3, 0); cycle();
        chk("R3 soft reset wins", reg_rdata, 32'h0);
        set_op(1, 7'd3, 32'h0000_0800); cycle();
        hw_reset();
        set_op(0, 7'd3, 0); cycle();
        chk("R3 hw reset mask", reg_rdata, 32'h0);
        set_op(0, 7'd2, 0); cycle();
        chk("R5 hw reset keeps address", reg_rdata, 32'h0000_A55A);

        // R7 / R9 32-bit mode
        set_op(1, 7'd24, 32'hDEAD_BEEF); cycle();
        af_sel = 3'd1; #1;
        chk("R9 ptr0 32-bit", af_addr, 32'hDEAD_BEEF);
        af_sel = 3'd0; #1;
        chk("R9 init addr", af_addr, 32'hA55A_0000);
        // R8 24-bit mode
        mode32 = 0; set_op(1, 7'd25, 32'h1122_3344); cycle();
        set_op(0, 7'd25, 0); cycle();
        chk("R8 spliced write", reg_rdata, 32'hA522_3344);
        set_op(1, 7'd2, 32'h0000_3C00); cycle();
        set_op(0, 7'd24, 0); cycle(); cycle();
        chk("R8 refreshed byte", reg_rdata, 32'h3CAD_BEEF);
        mode32 = 1; cycle();
        chk("R7 stays after mode change", reg_rdata, 32'h3CAD_BEEF);
        set_op(0, 7'd100, 0); cycle();

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom % 10;
            logic [6:0] idx;
            if (r < 2) idx = 7'd2;
            else if (r == 2) idx = 7'd17;
            else if (r < 5) idx = 7'd3;
            else if (r < 9) idx = 7'(24 + ($urandom % NP));
            else idx = 7'(40 + ($urandom % 20));
            set_op(($urandom % 2) == 0, idx, $urandom);
            ctl_stop = ($urandom % 3) == 0;
            ctl_suspend = ($urandom % 3) == 0;
            soft_rst = ($urandom % 40) == 0;
            if (($urandom % 50) == 0) mode32 = ~mode32;
            st_miss = $urandom; st_merr = $urandom; st_rint = $urandom;
            af_sel = SW'($urandom % (NP + 2));
            #1;
            comb_checks(1);
            cycle();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule